// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block turns a logical address, given as a 16-bit selector plus a 32-bit offset, into a 32-bit linear address. A small set of segment slots each hold a decoded copy of one descriptor. Software fills a slot with a load command. The block then chooses the global or local descriptor table from the selector, reads the 8-byte descriptor as two 32-bit words over a simple read port, and checks presence and privilege. If both checks pass, it writes the base, the effective limit and the privilege level into the slot.

Once a slot is loaded, translations through it use only registers. Each translation compares the offset against the cached limit and the current privilege against the cached descriptor privilege. If both checks pass, it adds the cached base to the offset. The result appears one cycle after the request, with a 2-bit fault code. Fault codes are 0 for success, 1 for not present, 2 for privilege violation and 3 for limit violation, and the same codes are used for loads and for translations.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `ld_ready` is 1 and `ld_done`, `mem_req_valid` and `rs_valid` are 0. After a load completes, the block returns to idle with `ld_ready` high on the next cycle.
- R2: A load selects the local table base when selector bit 2 is 1 and the global table base when it is 0. The table index is selector bits 15:3. The first read goes to base + index*8 and fetches the low word. The second read goes to that address + 4 and fetches the high word.
- R3: The descriptor is decoded as follows. From the low word, bits 15:0 are limit[15:0] and bits 31:16 are base[15:0]. From the high word, bits 7:0 are base[23:16], bits 14:13 are the privilege, bit 15 is present, bits 19:16 are limit[19:16], bit 23 is granularity and bits 31:24 are base[31:24]. When granularity is 1, the effective limit is (limit << 12) | 0xFFF; otherwise it is the 20-bit limit.
- R4: A translation that passes its checks returns base + offset modulo 2^32, with `rs_valid` high exactly one cycle after `xl_valid` and a fault code of 0.
- R5: An offset above the effective limit returns fault code 3 with `rs_addr` equal to 0.
- R6: Loading a descriptor whose present bit is 0 reports fault code 1 at `ld_done` and leaves the slot's previous contents in use.
- R7: A load reports fault code 2, and leaves the slot unchanged, when the larger of `cur_priv` and selector bits 1:0 is numerically greater than the descriptor privilege.
- R8: A translation returns fault code 2 when `cur_priv` is greater than the slot's cached privilege.
- R9: A translation through a slot that has never been loaded successfully returns fault code 1.
- R10: Translations issue no memory reads. Each load issues exactly two.
- R11: When a translation is accepted in the same cycle as a load completes on the same slot, the translation uses the slot contents from before the load.
- R12: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gtab_base | input | 32 | Global descriptor table base |
| ltab_base | input | 32 | Local descriptor table base |
| cur_priv | input | 2 | Current privilege level |
| ld_valid | input | 1 | Load command strobe |
| ld_ready | output | 1 | Load engine idle |
| ld_seg | input | SW | Slot to load |
| ld_sel | input | 16 | Selector to load |
| ld_done | output | 1 | Load finished (one cycle) |
| ld_fault | output | 2 | Load fault code |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| xl_valid | input | 1 | Translate request |
| xl_seg | input | SW | Slot used for translation |
| xl_off | input | 32 | Offset |
| rs_valid | output | 1 | Translation result valid |
| rs_addr | output | 32 | Linear address (0 on fault) |
| rs_fault | output | 2 | Translation fault code |

## Verification
Two functions can act in the same cycle: a load writing its slot and a translation reading that slot. To provoke this, the bench stalls the memory port so the load finishes late. It then waits at a falling edge for `ld_done`, and raises `xl_valid` in that same cycle for the slot being reloaded. The scoreboard computes the expected result from the slot contents before the load, and checks that the next translation sees the new base.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int NSEG = 4,
  localparam int SW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   gtab_base,
  input  logic [31:0]   ltab_base,
  input  logic [1:0]    cur_priv,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [SW-1:0] ld_seg,
  input  logic [15:0]   ld_sel,
  output logic          ld_done,
  output logic [1:0]    ld_fault,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [31:0]   mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  input  logic          xl_valid,
  input  logic [SW-1:0] xl_seg,
  input  logic [31:0]   xl_off,
  output logic          rs_valid,
  output logic [31:0]   rs_addr,
  output logic [1:0]    rs_fault
);

  localparam logic [1:0] F_OK = 2'd0, F_NP = 2'd1, F_PRIV = 2'd2, F_LIM = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_REQ0, S_WAIT0, S_REQ1, S_WAIT1, S_DONE} st_t;

  st_t          st;
  logic [SW-1:0] seg_q;
  logic [15:0]  sel_q;
  logic [31:0]  taddr_q, w0, w1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE:  if (ld_valid) st <= S_REQ0;
        S_REQ0:  if (mem_req_ready) st <= S_WAIT0;
        S_WAIT0: if (mem_rsp_valid) st <= S_REQ1;
        S_REQ1:  if (mem_req_ready) st <= S_WAIT1;
        S_WAIT1: if (mem_rsp_valid) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_IDLE && ld_valid) begin
      seg_q   <= ld_seg;
      sel_q   <= ld_sel;
      taddr_q <= (ld_sel[2] ? ltab_base : gtab_base) + {16'b0, ld_sel[15:3], 3'b000};
    end
    if (st == S_WAIT0 && mem_rsp_valid) w0 <= mem_rsp_data;
    if (st == S_WAIT1 && mem_rsp_valid) w1 <= mem_rsp_data;
  end

  assign ld_ready      = (st == S_IDLE);
  assign mem_req_valid = (st == S_REQ0) || (st == S_REQ1);
  assign mem_req_addr  = taddr_q + ((st == S_REQ1) ? 32'd4 : 32'd0);

  logic [31:0] d_base, d_elim;
  logic [19:0] d_lim;
  logic [1:0]  d_dpl, need_pl;
  logic        d_g, d_p;
  logic        unused_attr;

  assign d_base  = {w1[31:24], w1[7:0], w0[31:16]};
  assign d_lim   = {w1[19:16], w0[15:0]};
  assign d_g     = w1[23];
  assign d_p     = w1[15];
  assign d_dpl   = w1[14:13];
  assign d_elim  = d_g ? {d_lim, 12'hFFF} : {12'h000, d_lim};
  assign need_pl = (cur_priv > sel_q[1:0]) ? cur_priv : sel_q[1:0];
  assign unused_attr = ^{w1[22:20], w1[12:8]};

  assign ld_done  = (st == S_DONE);
  assign ld_fault = !ld_done ? F_OK :
                    !d_p     ? F_NP :
                    (need_pl > d_dpl) ? F_PRIV : F_OK;

  logic        sh_ok   [NSEG];
  logic [31:0] sh_base [NSEG];
  logic [31:0] sh_lim  [NSEG];
  logic [1:0]  sh_dpl  [NSEG];
  logic        commit;

  assign commit = ld_done && (ld_fault == F_OK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) sh_ok[i] <= 1'b0;
    end else if (commit) begin
      sh_ok[seg_q] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      sh_base[seg_q] <= d_base;
      sh_lim[seg_q]  <= d_elim;
      sh_dpl[seg_q]  <= d_dpl;
    end
  end

  logic [1:0] t_code;
  assign t_code = !sh_ok[xl_seg]                ? F_NP   :
                  (cur_priv > sh_dpl[xl_seg])   ? F_PRIV :
                  (xl_off > sh_lim[xl_seg])     ? F_LIM  : F_OK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_addr  <= '0;
      rs_fault <= F_OK;
    end else begin
      rs_valid <= xl_valid;
      if (xl_valid) begin
        rs_fault <= t_code;
        rs_addr  <= (t_code == F_OK) ? sh_base[xl_seg] + xl_off : 32'd0;
      end
    end
  end

  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r4_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid |=> rs_valid);

  a_r4_no_stray_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_valid |=> !rs_valid);

  a_r5_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && rs_fault != F_OK |-> rs_addr == 32'd0);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready |-> !mem_req_valid);

  a_r1_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |=> ld_ready);

  a_r6_failed_load_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done && ld_fault != F_OK |=> $stable(sh_ok[seg_q]) &&
      (!sh_ok[seg_q] || $stable(sh_base[seg_q])));

endmodule

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] GB = 32'h0001_0000;
  localparam logic [31:0] LB = 32'h0002_0000;

  logic        clk = 0, rst_n = 0;
  logic [1:0]  cur_priv = 0;
  logic        ld_valid = 0, ld_ready, ld_done;
  logic [1:0]  ld_seg = 0, ld_fault;
  logic [15:0] ld_sel = 0;
  logic        mem_req_valid, mem_req_ready = 0, mem_rsp_valid = 0;
  logic [31:0] mem_req_addr, mem_rsp_data = 0;
  logic        xl_valid = 0, rs_valid;
  logic [1:0]  xl_seg = 0, rs_fault;
  logic [31:0] xl_off = 0, rs_addr;

  seg_xlate u_seg_xlate (
    .clk(clk), .rst_n(rst_n), .gtab_base(GB), .ltab_base(LB), .cur_priv(cur_priv),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_seg(ld_seg), .ld_sel(ld_sel),
    .ld_done(ld_done), .ld_fault(ld_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .xl_valid(xl_valid), .xl_seg(xl_seg), .xl_off(xl_off),
    .rs_valid(rs_valid), .rs_addr(rs_addr), .rs_fault(rs_fault));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  bit [31:0] mem [bit [31:0]];
  task automatic put_desc(input logic [31:0] tb, input int idx, input logic [31:0] base,
                          input logic [19:0] lim, input bit g, input bit p, input logic [1:0] dpl);
    logic [31:0] a;
    a = tb + 32'(idx) * 8;
    mem[a]     = {base[15:0], lim[15:0]};
    mem[a + 4] = {base[31:24], g, 1'b1, 1'b0, 1'b0, lim[19:16], p, dpl, 1'b1, 4'hA, base[23:16]};
  endtask

  int          req_count = 0, stall_left = 0;
  logic [31:0] addr_log [$];
  initial begin
    bit pend = 0, stalling = 0;
    logic [31:0] pdata = 0, held = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (pend) begin
        mem_rsp_valid = 1; mem_rsp_data = pdata; pend = 0;
      end
      if (mem_req_valid) begin
        if (stall_left > 0) begin
          if (!stalling) begin stalling = 1; held = mem_req_addr; end
          else check(mem_req_addr == held, "R12 stalled address", mem_req_addr, held);
          stall_left--; mem_req_ready = 0;
        end else begin
          if (stalling) check(mem_req_addr == held, "R12 stalled address", mem_req_addr, held);
          stalling = 0;
          mem_req_ready = 1;
          req_count++;
          addr_log.push_back(mem_req_addr);
          pdata = mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
          pend = 1;
        end
      end else mem_req_ready = 0;
    end
  end

  bit          m_ok [4];
  logic [31:0] m_base [4], m_lim [4];
  logic [1:0]  m_dpl [4];
  logic [31:0] q_addr [$];
  logic [1:0]  q_code [$];
  string       q_tag [$];

  task automatic xl_drive(input int seg, input logic [31:0] off, input string tag);
    logic [1:0] c;
    c = !m_ok[seg] ? 2'd1 : (cur_priv > m_dpl[seg]) ? 2'd2 : (off > m_lim[seg]) ? 2'd3 : 2'd0;
    q_code.push_back(c);
    q_addr.push_back(c == 2'd0 ? m_base[seg] + off : 32'd0);
    q_tag.push_back(tag);
    xl_valid = 1; xl_seg = 2'(seg); xl_off = off;
  endtask

  task automatic xl(input int seg, input logic [31:0] off, input string tag);
    @(negedge clk); xl_drive(seg, off, tag);
    @(negedge clk); xl_valid = 0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rs_valid) begin
        if (q_code.size() == 0) check(0, "R4 unexpected result", rs_addr, 32'h0);
        else begin
          logic [31:0] ea; logic [1:0] ec; string t;
          ea = q_addr.pop_front(); ec = q_code.pop_front(); t = q_tag.pop_front();
          check(rs_fault == ec, {t, " code"}, 32'(rs_fault), 32'(ec));
          check(rs_addr == ea, {t, " addr"}, rs_addr, ea);
        end
      end
    end
  end

  task automatic do_load(input int seg, input logic [15:0] sel, input logic [1:0] exp_code,
                         input logic [31:0] nb, input logic [31:0] nl, input logic [1:0] nd,
                         input string tag, input bit xl_now, input logic [31:0] xoff);
    addr_log.delete();
    @(negedge clk); ld_valid = 1; ld_seg = 2'(seg); ld_sel = sel;
    @(negedge clk); ld_valid = 0;
    while (!ld_done) @(negedge clk);
    check(ld_fault == exp_code, tag, 32'(ld_fault), 32'(exp_code));
    if (xl_now) xl_drive(seg, xoff, "R11 same-cycle translate");
    if (exp_code == 2'd0) begin
      m_ok[seg] = 1; m_base[seg] = nb; m_lim[seg] = nl; m_dpl[seg] = nd;
    end
    @(negedge clk); xl_valid = 0;
    check(ld_ready == 1, "R1 idle after load", 32'(ld_ready), 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog expired", 32'h0, 32'h1);
    finish_up();
  end

  initial begin
    int rc;
    put_desc(GB, 5,  32'h1000_0000, 20'hFFFFF, 1, 1, 2'd3);
    put_desc(LB, 2,  32'h8000_0000, 20'h00FFF, 0, 1, 2'd0);
    put_desc(LB, 3,  32'h7000_0000, 20'hFFFFF, 1, 0, 2'd0);
    put_desc(GB, 9,  32'h0300_0000, 20'h00003, 1, 1, 2'd0);
    put_desc(GB, 10, 32'h0500_0000, 20'h000FF, 0, 1, 2'd2);
    put_desc(GB, 11, 32'h4000_0000, 20'hFFFFF, 1, 1, 2'd0);

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(ld_ready == 1, "R1 ld_ready after reset", 32'(ld_ready), 32'h1);
    check(ld_done == 0 && mem_req_valid == 0 && rs_valid == 0, "R1 outputs idle after reset",
          {29'b0, ld_done, mem_req_valid, rs_valid}, 32'h0);

    do_load(0, 16'h0028, 2'd0, 32'h1000_0000, 32'hFFFF_FFFF, 2'd3, "R2 global load", 0, 0);
    check(addr_log.size() == 2, "R10 two reads per load", addr_log.size(), 2);
    if (addr_log.size() == 2) begin
      check(addr_log[0] == GB + 40, "R2 global first word", addr_log[0], GB + 40);
      check(addr_log[1] == GB + 44, "R2 global second word", addr_log[1], GB + 44);
    end
    do_load(1, 16'h0014, 2'd0, 32'h8000_0000, 32'h0000_0FFF, 2'd0, "R2 local load", 0, 0);
    if (addr_log.size() == 2) begin
      check(addr_log[0] == LB + 16, "R2 local first word", addr_log[0], LB + 16);
      check(addr_log[1] == LB + 20, "R2 local second word", addr_log[1], LB + 20);
    end else check(0, "R2 local read count", addr_log.size(), 2);

    rc = req_count;
    xl(0, 32'h0000_1234, "R4 base plus offset");
    xl(0, 32'hFFFF_FFF0, "R4 wraparound");
    xl(1, 32'h0000_0FFF, "R3 byte limit edge");
    xl(1, 32'h0000_1000, "R5 byte limit exceeded");
    xl(2, 32'h0000_0000, "R9 unloaded slot");
    repeat (2) @(negedge clk);
    check(req_count == rc, "R10 no reads on translate", req_count, rc);

    do_load(2, 16'h0038, 2'd1, 0, 0, 0, "R6 absent descriptor", 0, 0);
    xl(2, 32'h0, "R9 still unloaded after failed load");
    do_load(1, 16'h001C, 2'd1, 0, 0, 0, "R6 present bit clear", 0, 0);
    xl(1, 32'h0000_0FFF, "R6 slot kept");

    do_load(3, 16'h004B, 2'd2, 0, 0, 0, "R7 requested privilege too weak", 0, 0);
    cur_priv = 2'd3;
    do_load(3, 16'h0048, 2'd2, 0, 0, 0, "R7 current privilege too weak", 0, 0);
    cur_priv = 2'd0;
    xl(3, 32'h0, "R7 slot not filled");
    do_load(3, 16'h0048, 2'd0, 32'h0300_0000, 32'h0000_3FFF, 2'd0, "R7 privilege ok", 0, 0);
    xl(3, 32'h0000_3FFF, "R3 page-granular limit edge");
    xl(3, 32'h0000_4000, "R5 page-granular limit exceeded");
    cur_priv = 2'd1;
    do_load(2, 16'h0052, 2'd0, 32'h0500_0000, 32'h0000_00FF, 2'd2, "R7 max equal to dpl", 0, 0);

    cur_priv = 2'd3;
    xl(3, 32'h0, "R8 translate privilege fault");
    xl(0, 32'h8, "R8 translate at dpl 3");
    xl(2, 32'h0, "R8 translate above dpl 2");
    cur_priv = 2'd2;
    xl(2, 32'h0000_00FF, "R4 dpl 2 slot");
    xl(2, 32'h0000_0100, "R5 dpl 2 slot limit");

    cur_priv = 2'd0;
    stall_left = 4;
    do_load(1, 16'h0058, 2'd0, 32'h4000_0000, 32'hFFFF_FFFF, 2'd0, "R12 stalled load", 1, 32'h10);
    xl(1, 32'h0000_0010, "R11 new contents after load");

    repeat (4) @(negedge clk);
    check(q_code.size() == 0, "R4 all results returned", q_code.size(), 0);
    finish_up();
  end
endmodule